// File: doc/BRIEF.md
# Burst Multiply-Accumulate Engine

The engine forms the sum of products of a fixed-length burst of unsigned operand pairs. Two handshakes surround it. On the source side it pulls data by raising a request and waiting for a grant. On the sink side it waits to be asked for its result and then acknowledges. Both exchanges follow a four-phase return-to-zero discipline.

A burst runs as follows. The engine raises `src_req` and waits in WAIT_GRANT. When it samples `src_ack` high, it takes the first pair on that same clock edge and moves to STREAM. In STREAM it takes one pair on every following edge, and a pair timer counts the pairs taken. After the final pair the engine drops `src_req` and moves to DRAIN. DRAIN lets the last registered pair reach the accumulator. In WAIT_SINK the engine waits for `snk_req`, latches the sum and enters PRESENT, where `snk_ack` is high. It leaves PRESENT when `snk_req` falls and enters WAIT_RELEASE. It leaves WAIT_RELEASE when `src_ack` is low, moves to IDLE, and one cycle later starts the next burst in WAIT_GRANT.

Each operand passes through an input register, so the multiply and the accumulate share one whole clock cycle. The datapath registers load only under enables driven by the controller.

Top module: `mac_burst_unit`

## Requirements
- R1: While `rst` is sampled high, `src_req` and `snk_ack` go low, `result` goes to 0 and any burst in progress is abandoned.
- R2: Outside reset, the engine raises `src_req` to start a burst and keeps it high without taking operands until `src_ack` is sampled high.
- R3: The first pair is taken on the edge at which `src_ack` is first sampled high. After that, one pair is taken on each consecutive edge until exactly BURST_LEN (225) pairs are in. `src_req` is low from the edge that takes the last pair and stays low during the output exchange.
- R4: `result` equals the sum over the burst of `op_a`×`op_b` as unsigned 8-bit values, in 24 bits. The accumulator starts from zero in every burst, including the first burst after a reset that cut off an earlier burst.
- R5: `snk_ack` rises only after `snk_req` has been sampled high while the sum is complete. While `snk_ack` is high, `result` holds the final sum and does not change.
- R6: If `snk_req` is already high, `snk_ack` rises no more than 6 clock edges after the edge that took the last pair.
- R7: `snk_ack` falls on the first edge at which `snk_req` is sampled low during PRESENT.
- R8: After the output exchange, `src_req` stays low for as long as `src_ack` is high. It rises again within two edges once `src_ack` is low.
- R9: Operand values driven while no burst is streaming have no effect. `result` keeps the last presented sum until the next sum is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_req | output | 1 | Request for operand pairs |
| src_ack | input | 1 | Grant from the operand source |
| op_a | input | 8 | First operand, unsigned |
| op_b | input | 8 | Second operand, unsigned |
| snk_req | input | 1 | Request for the result from the sink |
| snk_ack | output | 1 | Result valid / acknowledge to the sink |
| result | output | 24 | Accumulated sum of products |

## Verification
The hardest condition to reach from the ports is a reset in the middle of a stream: the pair timer, the input stage and the accumulator all hold partial burst state at that moment. The stimulus grants a burst, feeds 50 pairs, and then asserts reset. The next complete burst must then give exactly its own sum. Other runs hold the grant or the sink request back for several cycles, and keep `src_ack` high after the output exchange. These runs show that the engine waits in each handshake state and that operand noise driven during the waits does not reach the sum.

// File: rtl/mac_burst_pkg.sv
package mac_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GRANT,
        ST_STREAM,
        ST_DRAIN,
        ST_WAIT_SINK,
        ST_PRESENT,
        ST_WAIT_RELEASE
    } mac_state_e;

endpackage

// File: rtl/mac_pair_timer.sv
module mac_pair_timer #(
    parameter int BURST_LEN = 225,
    parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic final_pair
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

    logic [CNT_W-1:0] pairs_taken;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pairs_taken <= '0;
        end else if (step) begin
            pairs_taken <= pairs_taken + 1'b1;
        end
    end

    // the pair being taken this cycle is the last one of the burst
    assign final_pair = (pairs_taken == LAST_IDX);

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_burst_pkg::*;
#(
    parameter int BURST_LEN = 225
) (
    input  logic clk,
    input  logic rst,
    input  logic src_ack,
    input  logic snk_req,
    input  logic final_pair,
    output logic take,
    output logic clr_acc,
    output logic clr_timer,
    output logic load_res,
    output logic out_pending,
    output logic src_req,
    output logic snk_ack
);
    mac_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:         state_nx = ST_WAIT_GRANT;
            ST_WAIT_GRANT:   if (src_ack) state_nx = final_pair ? ST_DRAIN : ST_STREAM;
            ST_STREAM:       if (final_pair) state_nx = ST_DRAIN;
            ST_DRAIN:        state_nx = ST_WAIT_SINK;
            ST_WAIT_SINK:    if (snk_req) state_nx = ST_PRESENT;
            ST_PRESENT:      if (!snk_req) state_nx = ST_WAIT_RELEASE;
            ST_WAIT_RELEASE: if (!src_ack) state_nx = ST_IDLE;
            default:         state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        take        = 1'b0;
        clr_acc     = 1'b0;
        clr_timer   = 1'b0;
        load_res    = 1'b0;
        out_pending = 1'b0;
        src_req     = 1'b0;
        snk_ack     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clr_timer = 1'b1;
            end
            ST_WAIT_GRANT: begin
                src_req = 1'b1;
                take    = src_ack;
                clr_acc = src_ack;
            end
            ST_STREAM: begin
                src_req = 1'b1;
                take    = 1'b1;
            end
            ST_DRAIN: begin
                out_pending = 1'b1;
            end
            ST_WAIT_SINK: begin
                out_pending = 1'b1;
                load_res    = snk_req;
            end
            ST_PRESENT: begin
                snk_ack = 1'b1;
            end
            ST_WAIT_RELEASE: begin
                clr_timer = 1'b1;
            end
            default: begin
                clr_timer = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mac_in_stage.sv
module mac_in_stage #(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    output logic [OP_W-1:0] a_q,
    output logic [OP_W-1:0] b_q,
    output logic            vld_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= take;
            if (take) begin
                a_q <= a_in;
                b_q <= b_in;
            end
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int OP_W  = 8,
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             vld,
    input  logic             load_res,
    input  logic [OP_W-1:0]  a_q,
    input  logic [OP_W-1:0]  b_q,
    output logic [ACC_W-1:0] result
);
    localparam int PROD_W = 2 * OP_W;

    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0]  acc;

    assign prod = a_q * b_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (vld) begin
            acc <= acc + ACC_W'(prod);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (load_res) begin
            result <= acc;
        end
    end

endmodule

// File: rtl/mac_burst_unit.sv
module mac_burst_unit #(
    parameter int OP_W      = 8,
    parameter int ACC_W     = 24,
    parameter int BURST_LEN = 225
) (
    input  logic             clk,
    input  logic             rst,
    output logic             src_req,
    input  logic             src_ack,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             snk_req,
    output logic             snk_ack,
    output logic [ACC_W-1:0] result
);
    logic            take;
    logic            clr_acc;
    logic            clr_timer;
    logic            load_res;
    logic            out_pending;
    logic            final_pair;
    logic [OP_W-1:0] a_q;
    logic [OP_W-1:0] b_q;
    logic            vld_q;

    mac_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .src_ack    (src_ack),
        .snk_req    (snk_req),
        .final_pair (final_pair),
        .take       (take),
        .clr_acc    (clr_acc),
        .clr_timer  (clr_timer),
        .load_res   (load_res),
        .out_pending(out_pending),
        .src_req    (src_req),
        .snk_ack    (snk_ack)
    );

    mac_pair_timer #(.BURST_LEN(BURST_LEN)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_timer),
        .step      (take),
        .final_pair(final_pair)
    );

    mac_in_stage #(.OP_W(OP_W)) u_in (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .a_in (op_a),
        .b_in (op_b),
        .a_q  (a_q),
        .b_q  (b_q),
        .vld_q(vld_q)
    );

    mac_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_acc),
        .vld     (vld_q),
        .load_res(load_res),
        .a_q     (a_q),
        .b_q     (b_q),
        .result  (result)
    );

endmodule

// File: rtl/mac_burst_checker.sv
module mac_burst_checker #(
    parameter int ACC_W     = 24,
    parameter int BURST_LEN = 225,
    parameter int LAT_MAX   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             src_req,
    input logic             src_ack,
    input logic             snk_req,
    input logic             snk_ack,
    input logic             take,
    input logic             out_pending,
    input logic [ACC_W-1:0] result
);
    localparam int NW = $clog2(BURST_LEN + 2);

    logic [NW-1:0] ncap;
    logic [3:0]    lat;

    always_ff @(posedge clk) begin
        if (rst || !src_req) begin
            ncap <= '0;
        end else if (take) begin
            ncap <= ncap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !out_pending) begin
            lat <= '0;
        end else if (snk_req && lat != 4'hF) begin
            lat <= lat + 1'b1;
        end
    end

    AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (rst)
        take |-> (ncap < NW'(BURST_LEN)));                                  // R3
    AST_FULL_BURST: assert property (@(posedge clk) disable iff (rst)
        $fell(src_req) |-> (ncap == NW'(BURST_LEN)));                       // R3
    AST_REQ_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(src_req && snk_ack));                                             // R3
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(snk_ack) |-> $past(snk_req));                                 // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (snk_ack && $past(snk_ack)) |-> $stable(result));                   // R5
    AST_SINK_LATENCY: assert property (@(posedge clk) disable iff (rst)
        lat <= 4'(LAT_MAX));                                                // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(snk_ack) |-> !$past(snk_req));                                // R7
    AST_RESTART_GATE: assert property (@(posedge clk) disable iff (rst)
        $rose(src_req) |-> !$past(src_ack));                                // R8

endmodule

bind mac_burst_unit mac_burst_checker #(
    .ACC_W    (ACC_W),
    .BURST_LEN(BURST_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_req    (src_req),
    .src_ack    (src_ack),
    .snk_req    (snk_req),
    .snk_ack    (snk_ack),
    .take       (take),
    .out_pending(out_pending),
    .result     (result)
);

// File: tb/tb_mac_burst_unit.sv
module tb_mac_burst_unit;
    localparam int BURST = 225;
    localparam int NVEC  = 6;
    // {mode, seed, sink delay, grant delay}
    localparam logic [31:0] VECS [0:NVEC-1] = '{
        32'h00_00_00_00,
        32'h01_00_00_03,
        32'h02_07_14_00,
        32'h03_5A_00_05,
        32'h03_C3_09_01,
        32'h02_FF_00_00
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_ack = 1'b0;
    logic        snk_req = 1'b0;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic        src_req;
    logic        snk_ack;
    logic [23:0] result;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    mac_burst_unit dut (
        .clk(clk), .rst(rst), .src_req(src_req), .src_ack(src_ack),
        .op_a(a_in), .op_b(b_in), .snk_req(snk_req), .snk_ack(snk_ack),
        .result(result)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog: run hung, cycles=%0d expected<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fa(input int mode, input int seed, input int k);
        case (mode)
            0: fa = 8'hFF;
            1: fa = 8'h00;
            2: fa = 8'(k);
            default: fa = 8'(k * 37 + seed);
        endcase
    endfunction

    function automatic logic [7:0] fb(input int mode, input int seed, input int k);
        case (mode)
            0: fb = 8'hFF;
            1: fb = 8'h00;
            2: fb = 8'(seed);
            default: fb = 8'(k * 91 + seed * 3 + 7);
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_burst(input int mode, input int seed, input int sdly, input int gdly);
        logic [23:0] expv;
        logic [23:0] held;
        int n;
        int lat;
        int guard;
        expv = '0;
        for (int k = 0; k < BURST; k++) expv += 24'(fa(mode, seed, k)) * 24'(fb(mode, seed, k));
        if (sdly == 0) snk_req = 1'b1;
        guard = 0;
        while (!src_req && guard < 10) begin tick(); guard++; end
        chk(src_req == 1'b1, "R2", "request raised", src_req, 1);
        for (int i = 0; i < gdly; i++) begin
            a_in = 8'hFF; b_in = 8'hEE;
            tick();
            chk(src_req == 1'b1, "R2", "request held while grant low", src_req, 1);
        end
        src_ack = 1'b1;
        n = 0;
        while (n < BURST + 5) begin
            if (!src_req) break;
            a_in = fa(mode, seed, n);
            b_in = fb(mode, seed, n);
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk(n == BURST, "R3", "pairs taken while requesting", n, BURST);
        a_in = 8'hA5; b_in = 8'h5A;
        if (sdly == 0) begin
            lat = 0;
            while (!snk_ack && lat < 20) begin tick(); lat++; end
            chk(lat <= 6, "R6", "edges from last pair to ack", lat, 6);
        end else begin
            for (int i = 0; i < sdly; i++) begin
                a_in = 8'(i * 13); b_in = 8'(i * 29 + 1);
                tick();
                chk(snk_ack == 1'b0, "R5", "ack waits for sink request", snk_ack, 0);
            end
            snk_req = 1'b1;
            guard = 0;
            while (!snk_ack && guard < 10) begin tick(); guard++; end
            chk(snk_ack == 1'b1, "R5", "ack after sink request", snk_ack, 1);
        end
        chk(result == expv, "R4", "sum of products", result, expv);
        chk(src_req == 1'b0, "R3", "request low in output phase", src_req, 0);
        held = result;
        tick();
        chk(result == held, "R5", "result stable while ack high", result, held);
        snk_req = 1'b0;
        tick();
        chk(snk_ack == 1'b0, "R7", "ack dropped after sink release", snk_ack, 0);
        for (int i = 0; i < 4; i++) begin
            a_in = 8'(i * 71 + 3); b_in = 8'(i * 5 + 200);
            tick();
            chk(src_req == 1'b0, "R8", "no restart while grant high", src_req, 0);
        end
        chk(result == held, "R9", "result held between bursts", result, held);
        src_ack = 1'b0;
        guard = 0;
        while (!src_req && guard < 2) begin tick(); guard++; end
        chk(src_req == 1'b1, "R8", "restart after grant low", src_req, 1);
        chk(result == held, "R9", "idle operands ignored", result, held);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(src_req == 1'b0, "R1", "request low in reset", src_req, 0);
        chk(snk_ack == 1'b0, "R1", "ack low in reset", snk_ack, 0);
        chk(result == 24'd0, "R1", "result zero in reset", result, 0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            run_burst(int'(VECS[v][31:24]), int'(VECS[v][23:16]),
                      int'(VECS[v][15:8]), int'(VECS[v][7:0]));
        end

        // reset cut into a stream
        src_ack = 1'b1;
        for (int i = 0; i < 50; i++) begin
            a_in = 8'hF0; b_in = 8'hF0;
            tick();
        end
        rst = 1'b1;
        tick();
        chk(src_req == 1'b0, "R1", "request low after reset mid-burst", src_req, 0);
        chk(snk_ack == 1'b0, "R1", "ack low after reset mid-burst", snk_ack, 0);
        chk(result == 24'd0, "R1", "result cleared by reset", result, 0);
        src_ack = 1'b0;
        tick();
        rst = 1'b0;
        run_burst(3, 8'h21, 0, 2);
        run_burst(0, 0, 3, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule